// File: doc/BRIEF.md
# CRT Character-Clock Timing Generator

This block produces raster timing for a character-based display controller. The timing registers arrive in their biased legacy encoding. Horizontal fields are counted in 8-pixel character cells. Vertical fields are counted in scanlines, and bits 8 and 9 of the vertical fields sit in a shared overflow byte. The block removes each bias to recover the real counts. It then runs a character counter and a scanline counter, and from them drives horizontal sync, vertical sync, display enable, a line-start strobe and a frame-start strobe.

Every rising edge of `clk_i` is one character clock. The register inputs are held steady while the block runs. After any change to them the counters are restarted through reset. Vertical sync is positioned with plain scanline numbers, which carry no bias.

Top module: `crtc_timing_gen`

## Requirements
- R1: While reset is asserted and in the first character after release, both counters are zero. So `line_start_o`, `frame_start_o` and `de_o` are 1, `hsync_o` is 0 unless the decoded sync start is 0, and `vsync_o` is 0 unless `v_sync_start_i` is 0.
- R2: A scanline lasts `h_total_i` + 5 character clocks. `line_start_o` is 1 exactly in the first character of each line.
- R3: Within a displayed line, `de_o` is 1 for character positions 0 to `h_disp_end_i` inclusive, and 0 for the rest of the line.
- R4: `hsync_o` is 1 for character positions p with `h_sync_start_i` − 1 ≤ p < `h_sync_end_i` − 1.
- R5: A frame lasts V + 2 scanlines. V is the 10-bit value {`overflow_i`[5], `overflow_i`[0], `v_total_i`}, with `overflow_i`[5] as bit 9 and `overflow_i`[0] as bit 8.
- R6: Scanlines 0 to D inclusive are displayed. D is {`overflow_i`[6], `overflow_i`[1], `v_disp_end_i`}, with `overflow_i`[6] as bit 9 and `overflow_i`[1] as bit 8. On every later line of the frame, `de_o` stays 0.
- R7: `vsync_o` is 1 for every character of scanlines L with `v_sync_start_i` ≤ L < `v_sync_end_i`.
- R8: `frame_start_o` is 1 for exactly one character per frame: the first character of scanline 0. It is never 1 without `line_start_o`.
- R9: `overflow_i` bits 2, 3, 4 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| h_total_i | input | 8 | Characters per line minus 5 |
| h_disp_end_i | input | 8 | Displayed characters minus 1 |
| h_sync_start_i | input | 8 | Hsync start character plus 1 |
| h_sync_end_i | input | 8 | Hsync end character plus 1 |
| v_total_i | input | 8 | Low 8 bits of lines per frame minus 2 |
| v_disp_end_i | input | 8 | Low 8 bits of displayed lines minus 1 |
| overflow_i | input | 8 | Vertical high bits (0, 1, 5, 6 used) |
| v_sync_start_i | input | 10 | First vsync scanline |
| v_sync_end_i | input | 10 | First scanline after vsync |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| line_start_o | output | 1 | First character of a line |
| frame_start_o | output | 1 | First character of a frame |

## Verification
The assertions check three things on every cycle: each counter steps by one or holds, each counter stays below its decoded total, and the strobes last a single character with frame start nested inside line start. The bias removal, the bit positions taken from the overflow byte, and the sync and display windows are shown only by the bench. It runs a cycle-accurate model over whole frames for four configurations. These cover the minimum line and frame lengths, a frame whose total uses vertical bit 8, a frame whose total uses vertical bit 9, and an overflow byte with every unused bit set.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int REG_W = 8;
  localparam int H_CW  = REG_W + 1;  // total + 5 needs one more bit
  localparam int V_LW  = REG_W + 2;  // 10-bit vertical line numbers
  localparam int V_CW  = REG_W + 3;  // total + 2 needs one more bit

  typedef struct packed {
    logic [H_CW-1:0]  h_total;
    logic [REG_W-1:0] h_de_last;
    logic [REG_W-1:0] h_ss;
    logic [REG_W-1:0] h_se;
    logic [V_CW-1:0]  v_total;
    logic [V_LW-1:0]  v_de_last;
  } crtc_timing_t;
endpackage

// File: rtl/crtc_reg_decode.sv
module crtc_reg_decode
  import crtc_pkg::*;
(
  input  logic [REG_W-1:0] h_total_i,
  input  logic [REG_W-1:0] h_disp_end_i,
  input  logic [REG_W-1:0] h_sync_start_i,
  input  logic [REG_W-1:0] h_sync_end_i,
  input  logic [REG_W-1:0] v_total_i,
  input  logic [REG_W-1:0] v_disp_end_i,
  input  logic [REG_W-1:0] overflow_i,
  output crtc_timing_t     tim_o
);
  always_comb begin
    tim_o.h_total   = H_CW'(h_total_i) + H_CW'(5);
    tim_o.h_de_last = h_disp_end_i;
    tim_o.h_ss      = h_sync_start_i - REG_W'(1);
    tim_o.h_se      = h_sync_end_i - REG_W'(1);
    tim_o.v_total   = V_CW'({overflow_i[5], overflow_i[0], v_total_i}) + V_CW'(2);
    tim_o.v_de_last = {overflow_i[6], overflow_i[1], v_disp_end_i};
  end
endmodule

// File: rtl/crtc_axis_counter.sv
module crtc_axis_counter #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] total_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  // >= keeps the counter bounded if total shrinks under it
  assign wrap_o = (cnt_o >= total_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (adv_i)  cnt_o <= wrap_o ? '0 : cnt_o + W'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_o) |=> (cnt_o == $past(cnt_o) + W'(1))); // R2, R5
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_o)); // R5
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cnt_o < total_i) |=> (cnt_o < $past(total_i))); // R2, R5
endmodule

// File: rtl/crtc_window.sv
module crtc_window #(
  parameter int W = 8
) (
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] end_i,
  output logic         in_o
);
  assign in_o = (pos_i >= start_i) && (pos_i < end_i);
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] h_total_i,
  input  logic [REG_W-1:0] h_disp_end_i,
  input  logic [REG_W-1:0] h_sync_start_i,
  input  logic [REG_W-1:0] h_sync_end_i,
  input  logic [REG_W-1:0] v_total_i,
  input  logic [REG_W-1:0] v_disp_end_i,
  input  logic [REG_W-1:0] overflow_i,
  input  logic [V_LW-1:0]  v_sync_start_i,
  input  logic [V_LW-1:0]  v_sync_end_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             line_start_o,
  output logic             frame_start_o
);
  crtc_timing_t    tim;
  logic [H_CW-1:0] h_cnt;
  logic [V_CW-1:0] v_cnt;
  logic            h_wrap, v_wrap;

  crtc_reg_decode u_dec (
    .h_total_i, .h_disp_end_i, .h_sync_start_i, .h_sync_end_i,
    .v_total_i, .v_disp_end_i, .overflow_i, .tim_o(tim)
  );

  crtc_axis_counter #(.W(H_CW)) u_hcnt (
    .clk_i, .rst_ni, .adv_i(1'b1), .total_i(tim.h_total),
    .cnt_o(h_cnt), .wrap_o(h_wrap)
  );

  crtc_axis_counter #(.W(V_CW)) u_vcnt (
    .clk_i, .rst_ni, .adv_i(h_wrap), .total_i(tim.v_total),
    .cnt_o(v_cnt), .wrap_o(v_wrap)
  );

  crtc_window #(.W(H_CW)) u_hs (
    .pos_i(h_cnt), .start_i(H_CW'(tim.h_ss)), .end_i(H_CW'(tim.h_se)),
    .in_o(hsync_o)
  );

  crtc_window #(.W(V_CW)) u_vs (
    .pos_i(v_cnt), .start_i(V_CW'(v_sync_start_i)), .end_i(V_CW'(v_sync_end_i)),
    .in_o(vsync_o)
  );

  assign de_o          = (h_cnt <= H_CW'(tim.h_de_last)) && (v_cnt <= V_CW'(tim.v_de_last));
  assign line_start_o  = (h_cnt == '0);
  assign frame_start_o = line_start_o && (v_cnt == '0);

  AST_FRAME_IN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_start_o); // R8
  AST_LINE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |=> !line_start_o); // R2
  AST_FRAME_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o); // R8
  AST_VWRAP_AT_LINE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_wrap && h_wrap) |=> frame_start_o); // R5
endmodule

// File: tb/crtc_timing_gen_tb_top.sv
module crtc_timing_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ht, hde, hss, hse, vt, vde, ov;
  logic [9:0] vss, vse;
  logic hs, vs, de, ls, fs;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  crtc_timing_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .h_total_i(ht), .h_disp_end_i(hde),
    .h_sync_start_i(hss), .h_sync_end_i(hse), .v_total_i(vt),
    .v_disp_end_i(vde), .overflow_i(ov), .v_sync_start_i(vss),
    .v_sync_end_i(vse), .hsync_o(hs), .vsync_o(vs), .de_o(de),
    .line_start_o(ls), .frame_start_o(fs)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cfg(input int h_t, input int h_de, input int h_ss, input int h_se,
                         input int v_t, input int v_de, input int ovf,
                         input int v_ss, input int v_se, input int nframes);
    int htot, vtot, vdl, eh, ev;
    ht = 8'(h_t); hde = 8'(h_de); hss = 8'(h_ss); hse = 8'(h_se);
    vt = 8'(v_t); vde = 8'(v_de); ov = 8'(ovf);
    vss = 10'(v_ss); vse = 10'(v_se);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    htot = h_t + 5;                                              // R2
    vtot = (((ovf >> 5) & 1) << 9) + ((ovf & 1) << 8) + v_t + 2; // R5
    vdl  = (((ovf >> 6) & 1) << 9) + (((ovf >> 1) & 1) << 8) + v_de; // R6
    eh = 0; ev = 0;
    // R1 reset state
    chk(ls, 1'b1, "R1 line_start after reset");
    chk(fs, 1'b1, "R1 frame_start after reset");
    chk(de, 1'b1, "R1 de after reset");
    for (int c = 0; c < htot * vtot * nframes; c++) begin
      if (c != 0) @(negedge clk);
      chk(de, (eh <= h_de) && (ev <= vdl), (ev <= vdl) ? "R3 de" : "R6 de");
      chk(hs, (eh >= h_ss - 1) && (eh < h_se - 1), "R4 hsync");
      chk(vs, (ev >= v_ss) && (ev < v_se), "R7 vsync R9");
      chk(ls, eh == 0, "R2 line_start");
      chk(fs, (eh == 0) && (ev == 0), "R5 R8 frame_start");
      eh++;
      if (eh == htot) begin
        eh = 0;
        ev++;
        if (ev == vtot) ev = 0;
      end
    end
  endtask

  initial begin
    ht = '0; hde = '0; hss = '0; hse = '0; vt = '0; vde = '0; ov = '0;
    vss = '0; vse = '0;
    // typical small raster
    run_cfg(3, 4, 6, 8, 8, 5, 8'h10, 7, 9, 3);
    // minimum line and frame
    run_cfg(0, 0, 2, 3, 0, 0, 8'h10, 1, 2, 4);
    // vertical bit 8 for total and display end, unused overflow bits set (R9)
    run_cfg(1, 2, 3, 5, 2, 1, 8'h9F, 258, 259, 2);
    // vertical bit 9
    run_cfg(0, 3, 1, 4, 0, 0, 8'h60, 5, 8, 2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule